// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is the countdown timer that sits beside each processor in a local interrupt controller. Software programs three things through write strobes: a starting count, a divide setting that slows the input clock by a power of two, and a control word holding an interrupt vector, a mask bit and a mode bit that picks one-shot or periodic operation. Each write strobe is a single-cycle pulse that carries its own data word; the register decoding that produces these strobes sits outside the block.

The count drops by one on every prescaled tick. On the tick after the count has reached zero the timer expires. In one-shot mode it then stays at zero. In periodic mode it reloads the starting count, so one period lasts the starting count plus one ticks. Each expiry that occurs while the timer is unmasked produces a one-cycle request strobe carrying the programmed vector. Such a request is always edge type. The present count can be read at any time on a dedicated output.

Top module: `local_countdown_timer`

## Requirements
- R1: After reset, cur_count is 0 and irq_valid is 0. The control word is masked and in one-shot mode with vector 0. The divide code is 0, so the divider is by 2.
- R2: A divide write keeps only div_wdata bits 3, 1 and 0, forming code = {bit3, bit1, bit0}. Bit 2 has no effect. The shift is (code + 1) mod 8 and the timer ticks once every 2^shift clocks, so code 7 divides by 1 and code 6 divides by 128.
- R3: On a cnt_wr edge, cur_count takes cnt_wdata and the prescaler restarts. The first decrement follows 2^shift clocks after the write, and a new write abandons any countdown in progress.
- R4: In one-shot mode (control bit 17 = 0), a start value N expires once, exactly N+1 ticks after the write. cur_count then holds 0 and no further request occurs.
- R5: In periodic mode (control bit 17 = 1), each expiry reloads cur_count with N on the same edge. Expiries repeat every N+1 ticks.
- R6: An unmasked expiry raises irq_valid for one cycle, registered on the edge of the expiring tick. At the same time irq_vector equals control bits 7:0.
- R7: While control bit 16 (mask) is 1, expiries produce no request but counting and reloading continue. After an unmask, the next expiry produces a request and earlier expiries produce none.
- R8: A one-shot start value of 0 never produces a request, and cur_count reads 0.
- R9: A divide write that lands mid-count leaves cur_count unchanged. The new rate applies from the first tick after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Start-count write strobe |
| cnt_wdata | input | CNT_W | Start-count value |
| div_wr | input | 1 | Divide setting write strobe |
| div_wdata | input | 4 | Divide setting; bits 3,1,0 form the code |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W | Control word: bit 17 periodic, bit 16 mask, bits 7:0 vector |
| irq_valid | output | 1 | One-cycle request strobe |
| irq_vector | output | 8 | Vector delivered with the strobe |
| cur_count | output | CNT_W | Present count |

## Verification
A prescaler phase error shows on cur_count within one tick period: every decrement lands on an edge the bench can predict exactly. A wrong reload value or a lost expiry flag moves, adds or removes a request strobe. The scoreboard detects this by comparing every strobe against the exact edge and vector predicted for it, and it flags a request that should have come but did not as soon as that edge has passed. A divide decode that is off by one bit position shows as a 2x or larger error in the spacing of decrements.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int DIV_IN_W   = 4;
    localparam int DIV_CODE_W = 3;
    localparam int VEC_W      = 8;
    localparam int PERIOD_BIT = 17;
    localparam int MASK_BIT   = 16;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } ctl_t;

    // Scattered divide field: code is {w[3], w[1], w[0]}, shift is code+1 wrapped.
    function automatic logic [DIV_CODE_W-1:0] div_shift(input logic [DIV_IN_W-1:0] w);
        logic [DIV_CODE_W-1:0] code;
        code = {w[3], w[1], w[0]};
        return code + DIV_CODE_W'(1);
    endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                div_wr,
    input  logic [DIV_IN_W-1:0] div_wdata,
    input  logic                restart,
    output logic                tick
);

    localparam int PRE_W = (1 << DIV_CODE_W) - 1;

    typedef struct packed {
        logic [DIV_CODE_W-1:0] cfg;
        logic [DIV_CODE_W-1:0] act;
        logic [PRE_W-1:0]      pre;
    } pre_state_t;

    pre_state_t            st_d, st_q;
    logic [DIV_CODE_W-1:0] cfg_next;
    logic [PRE_W:0]        span;
    logic [PRE_W:0]        lim;
    logic                  div_unused_bit;

    assign div_unused_bit = div_wdata[2];

    always_comb begin
        st_d     = st_q;
        cfg_next = div_wr ? div_shift(div_wdata) : st_q.cfg;
        st_d.cfg = cfg_next;
        span     = (PRE_W+1)'(1) << st_q.act;
        lim      = span - (PRE_W+1)'(1);
        tick     = ({1'b0, st_q.pre} == lim);
        if (restart) begin
            st_d.pre = '0;
            st_d.act = cfg_next;
        end else if (tick) begin
            st_d.pre = '0;
            st_d.act = st_q.cfg;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= DIV_CODE_W'(1);
            st_q.act <= DIV_CODE_W'(1);
            st_q.pre <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload_val,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic [CNT_W-1:0] init;
        logic             armed;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cur   = load_val;
            st_d.init  = load_val;
            st_d.armed = (load_val != '0);
        end else if (tick) begin
            if (st_q.cur != '0) begin
                st_d.cur = st_q.cur - CNT_W'(1);
            end else if (periodic) begin
                expire     = 1'b1;
                st_d.cur   = st_q.init;
                st_d.armed = (st_q.init != '0);
            end else if (st_q.armed) begin
                expire     = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.cur;
    assign reload_val = st_q.init;

endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int CTL_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_wr,
    input  logic [CNT_W-1:0]    cnt_wdata,
    input  logic                div_wr,
    input  logic [DIV_IN_W-1:0] div_wdata,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    output logic                irq_valid,
    output logic [VEC_W-1:0]    irq_vector,
    output logic [CNT_W-1:0]    cur_count
);

    typedef struct packed {
        ctl_t             ctl;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] init_val;
    logic             ctl_mask;
    logic             ctl_periodic;
    logic [VEC_W-1:0] ctl_vector;
    logic             ctl_unused_bits;

    assign ctl_unused_bits = ^{ctl_wdata[CTL_W-1:PERIOD_BIT+1],
                               ctl_wdata[MASK_BIT-1:VEC_W]};

    lct_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .restart   (cnt_wr),
        .tick      (tick)
    );

    lct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_wr),
        .load_val   (cnt_wdata),
        .tick       (tick),
        .periodic   (st_q.ctl.periodic),
        .count      (cur_count),
        .reload_val (init_val),
        .expire     (expire)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl.periodic = ctl_wdata[PERIOD_BIT];
            st_d.ctl.masked   = ctl_wdata[MASK_BIT];
            st_d.ctl.vector   = ctl_wdata[VEC_W-1:0];
        end
        st_d.irq = expire && !st_q.ctl.masked;
        st_d.vec = st_q.ctl.vector;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl.periodic <= 1'b0;
            st_q.ctl.masked   <= 1'b1;
            st_q.ctl.vector   <= '0;
            st_q.irq          <= 1'b0;
            st_q.vec          <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_mask     = st_q.ctl.masked;
    assign ctl_periodic = st_q.ctl.periodic;
    assign ctl_vector   = st_q.ctl.vector;
    assign irq_valid    = st_q.irq;
    assign irq_vector   = st_q.vec;

endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             tick,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector,
    input logic [VEC_W-1:0] ctl_vector,
    input logic             ctl_mask,
    input logic             ctl_periodic,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] init_val
);

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cur_count == $past(cnt_wdata));

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !tick) |=> $stable(cur_count));

    assert_masked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(!ctl_mask));

    assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_vector == $past(ctl_vector));

    assert_irq_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(tick) && !$past(cnt_wr));

    // R4 / R5: count after an expiry is zero (one-shot) or the start value (periodic)
    assert_after_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> cur_count == ($past(ctl_periodic) ? init_val : '0));

endmodule

bind local_countdown_timer lct_checker #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (cnt_wdata),
    .tick         (tick),
    .irq_valid    (irq_valid),
    .irq_vector   (irq_vector),
    .ctl_vector   (ctl_vector),
    .ctl_mask     (ctl_mask),
    .ctl_periodic (ctl_periodic),
    .cur_count    (cur_count),
    .init_val     (init_val)
);

// File: tb/local_countdown_timer_tb.sv
module local_countdown_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [31:0] cnt_wdata = '0;
    logic        div_wr = 1'b0;
    logic [3:0]  div_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic [31:0] cur_count;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int         at;
        logic [7:0] vec;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    local_countdown_timer u_dut (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .cur_count(cur_count)
    );

    function automatic logic [31:0] mk_ctl(bit per, bit msk, logic [7:0] vec);
        return (32'(per) << 17) | (32'(msk) << 16) | 32'(vec);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic push(int at, logic [7:0] vec, string req);
        exp_t e;
        e.at = at; e.vec = vec; e.req = req;
        exp_q.push_back(e);
    endtask

    // All tasks start and end on a falling edge; edge_no is the rising edge that samples the write.
    task automatic wr_cnt(logic [31:0] v, output int edge_no);
        cnt_wr = 1'b1; cnt_wdata = v; edge_no = cyc + 1;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic wr_div(logic [3:0] v, output int edge_no);
        div_wr = 1'b1; div_wdata = v; edge_no = cyc + 1;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic wr_ctl(logic [31:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wait_until(int e);
        while (cyc < e) @(negedge clk);
    endtask

    // Scoreboard monitor: every strobe must match the head of the queue at its exact edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                n_chk++; n_bad++;
                $display("FAIL %s missing request actual none expected edge %0d", exp_q[0].req, exp_q[0].at);
                void'(exp_q.pop_front());
            end
            if (irq_valid) begin
                n_chk++;
                if (exp_q.size() == 0 || exp_q[0].at != cyc) begin
                    n_bad++;
                    $display("FAIL R6 unexpected request actual edge %0d expected %0d", cyc,
                             (exp_q.size() > 0) ? exp_q[0].at : -1);
                end else begin
                    if (irq_vector !== exp_q[0].vec) begin
                        n_bad++;
                        $display("FAIL %s vector actual %0h expected %0h", exp_q[0].req, irq_vector, exp_q[0].vec);
                    end
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c0, c1, c2, cw, cd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values; default masked one-shot at divide by 2
        chk("R1 count", cur_count, 0);
        chk("R1 strobe", 32'(irq_valid), 0);
        wr_cnt(3, c0);
        chk("R1 loaded", cur_count, 3);
        wait_until(c0 + 1); chk("R1 div2 hold", cur_count, 3);
        wait_until(c0 + 2); chk("R1 div2 tick", cur_count, 2);
        wait_until(c0 + 12); chk("R1 masked expiry", cur_count, 0);

        // R4 R6: one-shot at divide by 1
        wr_ctl(mk_ctl(0, 0, 8'h41));
        wr_div(4'hB, cd);
        wr_cnt(5, c0);
        push(c0 + 6, 8'h41, "R4");
        wait_until(c0 + 3); chk("R3 decrement", cur_count, 2);
        wait_until(c0 + 6); chk("R4 zero hold", cur_count, 0);
        wait_until(c0 + 20); chk("R4 stays zero", cur_count, 0);

        // R5: periodic reload, N=3 gives period 4
        wr_ctl(mk_ctl(1, 0, 8'h52));
        wr_cnt(3, c0);
        push(c0 + 4, 8'h52, "R5");
        push(c0 + 8, 8'h52, "R5");
        push(c0 + 12, 8'h52, "R5");
        wait_until(c0 + 4); chk("R5 reload", cur_count, 3);
        wait_until(c0 + 5); chk("R5 after reload", cur_count, 2);
        wait_until(c0 + 12);
        wr_ctl(mk_ctl(1, 1, 8'h52));
        wait_until(c0 + 20);

        // R2: code 6 -> divide by 128, bit 2 ignored
        wr_ctl(mk_ctl(0, 0, 8'h63));
        wr_div(4'b1010, cd);
        wr_cnt(2, c0);
        push(c0 + 384, 8'h63, "R2");
        wait_until(c0 + 127); chk("R2 div128 hold", cur_count, 2);
        wait_until(c0 + 128); chk("R2 div128 tick", cur_count, 1);
        wait_until(c0 + 390);
        wr_div(4'b0101, cd);          // code 1 -> divide by 4, bit 2 has no effect
        wr_cnt(1, c0);
        push(c0 + 8, 8'h63, "R2");
        wait_until(c0 + 3); chk("R2 div4 hold", cur_count, 1);
        wait_until(c0 + 4); chk("R2 div4 tick", cur_count, 0);
        wait_until(c0 + 12);

        // R7: masked periodic keeps counting; unmask fires only later expiries
        wr_ctl(mk_ctl(1, 1, 8'h74));
        wr_div(4'hB, cd);
        wr_cnt(2, c0);
        wait_until(c0 + 3); chk("R7 masked reload", cur_count, 2);
        wait_until(c0 + 7);
        push(c0 + 9, 8'h74, "R7");
        push(c0 + 12, 8'h74, "R7");
        wr_ctl(mk_ctl(1, 0, 8'h74));
        wait_until(c0 + 12);
        wr_ctl(mk_ctl(1, 1, 8'h74));
        wait_until(c0 + 20);

        // R8: one-shot start of zero never fires
        wr_cnt(0, c0);
        wr_ctl(mk_ctl(0, 0, 8'h11));
        wait_until(c0 + 20); chk("R8 zero count", cur_count, 0);

        // R3: rewrite restarts the countdown
        wr_cnt(10, c1);
        wait_until(c1 + 4); chk("R3 running", cur_count, 6);
        wr_cnt(3, c2);
        chk("R3 reloaded", cur_count, 3);
        push(c2 + 4, 8'h11, "R3");
        wait_until(c2 + 15); chk("R3 done", cur_count, 0);

        // R9: divide change mid-count
        wr_cnt(20, c0);
        wait_until(c0 + 4);
        wr_div(4'h0, cw);
        push(cw + 31, 8'h11, "R9");
        chk("R9 no reset", cur_count, 15);
        wait_until(cw + 1); chk("R9 last fast tick", cur_count, 14);
        wait_until(cw + 2); chk("R9 slow hold", cur_count, 14);
        wait_until(cw + 3); chk("R9 slow tick", cur_count, 13);
        wait_until(cw + 40); chk("R9 expired", cur_count, 0);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R6 pending requests actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule